// File: doc/BRIEF.md
# Register-Mapped Serial Byte Port

This block is the processor-facing side of a simple serial port. Software reaches it through a 32-bit slave bus. The bus takes word accesses only and answers each read one cycle after the request. A write to the data-out register sends its low byte on a parallel transmit strobe. Bytes that arrive on a valid/ready receive input are queued in a sixteen-entry FIFO.

Software reads the oldest queued byte, together with status flags, through one status/data word. That word has two addresses: one pops the byte and one only peeks at it. Interrupt causes are held in a raw register. A mask register selects which causes drive the single level interrupt output. Software clears causes by writing ones to an acknowledge register. The first acknowledge after a transmit leaves bit 0 alone.

Read responses come from a two-state machine. It stays in ST_IDLE while no read is requested. It takes the transition RD_ACCEPT to ST_RESP on any read request. From ST_RESP it takes RD_ACCEPT again if another read follows at once, or RESP_DONE back to ST_IDLE otherwise. The state machine drives `bus_rvalid` high only in ST_RESP.

Top module: `serport_ctrl`

## Requirements
- R1: After reset, receive control (word 0x08) reads 0x00010000. Transmit control (0x00), raw interrupt (0x34) and masked interrupt (0x38) read 0. The status word reads 0x01400000. `irq`, `rx_ready` and `tx_valid` are low.
- R2: A read request returns `bus_rvalid` high with its data in the next cycle. Words 0x00, 0x04, 0x08, 0x1C and 0x2C read back the last value written. Unmapped words such as 0x0C and 0x3C read 0. Writes to the masked interrupt word (0x38) are ignored.
- R3: The status word places the head byte in bits 7:0 and sets bit 16 when the FIFO is non-empty. Bits 22 and 24 are always set, and every other bit is clear.
- R4: A read at 0x24 never changes the FIFO. A read at 0x20 removes the head byte after returning it, but only when the FIFO is non-empty. A pop while empty leaves the FIFO empty.
- R5: The FIFO returns bytes in arrival order and holds 16 of them. When it is full, `rx_ready` is low and a presented byte is not taken.
- R6: Bytes are accepted only while bit 3 of receive control is set. With that bit clear, `rx_ready` is low.
- R7: A write to 0x1C raises `tx_valid` for exactly one cycle, in the cycle after the write, with `tx_data` equal to bits 7:0 of the written value. The same write sets raw interrupt bits 0 and 1.
- R8: A write to 0x30 clears the raw bits written as one, and 0x30 reads back the value actually applied. If a transmit has occurred since the last acknowledge, bit 0 of that value is forced to 0 for this one acknowledge.
- R9: Raw bit 3 takes the FIFO non-empty level only when a bus write or an accepted receive occurs. A pop that empties the FIFO leaves bit 3 set until the next such event. A direct write to 0x34 loads the other raw bits.
- R10: The masked word equals raw AND mask, and `irq` is high exactly when the masked word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (state ST_RESP) |
| bus_rdata | output | 32 | Read data |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be taken |
| irq | output | 1 | Level interrupt |

## Verification
Read data and `bus_rvalid` are due one cycle after the request edge. The bench drives every access at a falling edge and samples the response at the next falling edge, so it sees the registered value. Register effects of a write, the raw and masked interrupt bits and `irq` are due right after the write edge. `tx_valid` appears in the cycle after the write and is checked at that falling edge, and it is checked again one cycle later to be low. FIFO and raw bit 3 effects of a receive show after the accepting edge, and `rx_ready` is sampled before the edge that would take a byte.

// File: rtl/serport_pkg.sv
package serport_pkg;
    localparam int BUS_AW = 6;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = BUS_AW - 2;

    // word indices (byte offset / 4)
    localparam logic [IDX_W-1:0] W_TXCTRL = 4'h0;
    localparam logic [IDX_W-1:0] W_DMAEN  = 4'h1;
    localparam logic [IDX_W-1:0] W_RXCTRL = 4'h2;
    localparam logic [IDX_W-1:0] W_DOUT   = 4'h7;
    localparam logic [IDX_W-1:0] W_POP    = 4'h8;
    localparam logic [IDX_W-1:0] W_PEEK   = 4'h9;
    localparam logic [IDX_W-1:0] W_MASK   = 4'hB;
    localparam logic [IDX_W-1:0] W_ACK    = 4'hC;
    localparam logic [IDX_W-1:0] W_RAW    = 4'hD;
    localparam logic [IDX_W-1:0] W_MASKED = 4'hE;

    localparam int B_DAV    = 16;
    localparam int B_TXIDLE = 22;
    localparam int B_TXRDY  = 24;
    localparam int B_RXEN   = 3;
    localparam int B_RXLVL  = 3;

    localparam logic [DATA_W-1:0] RXCTRL_RST = 32'h0001_0000;

    typedef enum logic [0:0] {ST_IDLE, ST_RESP} bus_st_e;
endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         nonempty_nxt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          pop_ok;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign pop_ok = pop && !empty;
    assign head   = mem[rp_q];

    always_comb begin
        unique case ({push, pop_ok})
            2'b10:   cnt_n = cnt_q + 1'b1;
            2'b01:   cnt_n = cnt_q - 1'b1;
            default: cnt_n = cnt_q;
        endcase
    end
    assign nonempty_nxt = (cnt_n != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            if (push) begin
                mem[wp_q] <= din;
                wp_q      <= wp_q + 1'b1;
            end
            if (pop_ok) rp_q <= rp_q + 1'b1;
        end
    end

    // R5
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R4
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);
endmodule

// File: rtl/serport_irq.sv
module serport_irq #(
    parameter int DW  = 32,
    parameter int LVL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr,
    input  logic          ack_wr,
    input  logic          raw_wr,
    input  logic [DW-1:0] wdata,
    input  logic          upd,
    input  logic          level_nxt,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] raw_q,
    output logic [DW-1:0] ack_q,
    output logic [DW-1:0] masked,
    output logic          irq
);
    logic [DW-1:0] raw_n, ack_n, ackv;
    logic          pend_q, pend_n;

    always_comb begin
        raw_n  = raw_q;
        ack_n  = ack_q;
        pend_n = pend_q;
        ackv   = wdata;
        if (tx_wr) begin
            raw_n[1:0] = 2'b11;
            pend_n     = 1'b1;
        end
        if (ack_wr) begin
            if (pend_q) begin
                ackv[0] = 1'b0;
                pend_n  = 1'b0;
            end
            ack_n = ackv;
            raw_n = raw_n & ~ackv;
        end
        if (raw_wr) raw_n = wdata;
        if (upd) raw_n[LVL] = level_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            ack_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            raw_q  <= raw_n;
            ack_q  <= ack_n;
            pend_q <= pend_n;
        end
    end

    assign masked = raw_q & mask;
    assign irq    = |masked;

    // R7
    tx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (raw_q[1:0] == 2'b11) && pend_q);
    // R8
    ack_keep0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && pend_q) |=> (raw_q[0] == $past(raw_q[0])) && !pend_q);
    // R9
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> raw_q[LVL] == $past(raw_q[LVL]));
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
    import serport_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);
    bus_st_e           st_q, st_n;
    logic              wr, rd, push, pop;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] txctrl_q, dmaen_q, rxctrl_q, dout_q, mask_q;
    logic [DATA_W-1:0] raw, ack, masked, stat, rmux, rdata_q;
    logic [BYTE_W-1:0] head;
    logic              empty, full, nonempty_nxt;
    logic              txv_q;
    logic [BYTE_W-1:0] txd_q;

    assign wr   = bus_req && bus_we;
    assign rd   = bus_req && !bus_we;
    assign widx = bus_addr[BUS_AW-1:2];

    assign rx_ready = rxctrl_q[B_RXEN] && !full;
    assign push     = rx_valid && rx_ready;
    assign pop      = rd && (widx == W_POP);

    serport_rxq #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(push), .din(rx_data), .pop(pop),
        .head(head), .empty(empty), .full(full), .nonempty_nxt(nonempty_nxt)
    );

    serport_irq #(.DW(DATA_W), .LVL(B_RXLVL)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_wr(wr && widx == W_DOUT),
        .ack_wr(wr && widx == W_ACK),
        .raw_wr(wr && widx == W_RAW),
        .wdata(bus_wdata),
        .upd(wr || push),
        .level_nxt(nonempty_nxt),
        .mask(mask_q),
        .raw_q(raw), .ack_q(ack), .masked(masked), .irq(irq)
    );

    // plain storage registers and transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txctrl_q <= '0;
            dmaen_q  <= '0;
            rxctrl_q <= RXCTRL_RST;
            dout_q   <= '0;
            mask_q   <= '0;
            txv_q    <= 1'b0;
            txd_q    <= '0;
        end else begin
            txv_q <= 1'b0;
            if (wr) begin
                unique case (widx)
                    W_TXCTRL: txctrl_q <= bus_wdata;
                    W_DMAEN:  dmaen_q  <= bus_wdata;
                    W_RXCTRL: rxctrl_q <= bus_wdata;
                    W_MASK:   mask_q   <= bus_wdata;
                    W_DOUT: begin
                        dout_q <= bus_wdata;
                        txv_q  <= 1'b1;
                        txd_q  <= bus_wdata[BYTE_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end
    assign tx_valid = txv_q;
    assign tx_data  = txd_q;

    always_comb begin
        stat            = '0;
        stat[BYTE_W-1:0] = head;
        stat[B_DAV]     = !empty;
        stat[B_TXIDLE]  = 1'b1;
        stat[B_TXRDY]   = 1'b1;
    end

    always_comb begin
        unique case (widx)
            W_TXCTRL: rmux = txctrl_q;
            W_DMAEN:  rmux = dmaen_q;
            W_RXCTRL: rmux = rxctrl_q;
            W_DOUT:   rmux = dout_q;
            W_POP:    rmux = stat;
            W_PEEK:   rmux = stat;
            W_MASK:   rmux = mask_q;
            W_ACK:    rmux = ack;
            W_RAW:    rmux = raw;
            W_MASKED: rmux = masked;
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rmux;
    end
    assign bus_rdata = rdata_q;

    // read-response state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // next state and outputs
    always_comb begin
        st_n       = st_q;
        bus_rvalid = 1'b0;
        unique case (st_q)
            ST_IDLE: st_n = rd ? ST_RESP : ST_IDLE;
            ST_RESP: begin
                bus_rvalid = 1'b1;
                st_n       = rd ? ST_RESP : ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // R2
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);
    // R2
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_addr[1:0] == 2'b00);
    // R7
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid || $past(wr && widx == W_DOUT));
endmodule

// File: tb/serport_ctrl_bench.sv
module serport_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        irq;

    int nchk = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    serport_ctrl u_serport_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .irq(irq)
    );

    // {is_write, tag, byte address, data or expected read value}
    localparam int NV = 33;
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 4'd1, 8'h08, 32'h0001_0000},
        {1'b0, 4'd1, 8'h00, 32'h0000_0000},
        {1'b0, 4'd1, 8'h34, 32'h0000_0000},
        {1'b0, 4'd1, 8'h38, 32'h0000_0000},
        {1'b0, 4'd1, 8'h24, 32'h0140_0000},
        {1'b1, 4'd2, 8'h00, 32'hDEAD_BEEF},
        {1'b0, 4'd2, 8'h00, 32'hDEAD_BEEF},
        {1'b1, 4'd2, 8'h04, 32'h0000_0003},
        {1'b0, 4'd2, 8'h04, 32'h0000_0003},
        {1'b1, 4'd2, 8'h0C, 32'h0000_0055},
        {1'b0, 4'd2, 8'h0C, 32'h0000_0000},
        {1'b0, 4'd2, 8'h3C, 32'h0000_0000},
        {1'b1, 4'd2, 8'h2C, 32'h0000_000A},
        {1'b0, 4'd2, 8'h2C, 32'h0000_000A},
        {1'b1, 4'd2, 8'h38, 32'hFFFF_FFFF},
        {1'b0, 4'd2, 8'h38, 32'h0000_0000},
        {1'b1, 4'd7, 8'h1C, 32'h1234_56A5},
        {1'b0, 4'd2, 8'h1C, 32'h1234_56A5},
        {1'b0, 4'd7, 8'h34, 32'h0000_0003},
        {1'b0, 4'd10, 8'h38, 32'h0000_0002},
        {1'b1, 4'd8, 8'h30, 32'h0000_0003},
        {1'b0, 4'd8, 8'h30, 32'h0000_0002},
        {1'b0, 4'd8, 8'h34, 32'h0000_0001},
        {1'b1, 4'd8, 8'h30, 32'h0000_0001},
        {1'b0, 4'd8, 8'h30, 32'h0000_0001},
        {1'b0, 4'd8, 8'h34, 32'h0000_0000},
        {1'b1, 4'd9, 8'h34, 32'h0000_00F0},
        {1'b0, 4'd9, 8'h34, 32'h0000_00F0},
        {1'b0, 4'd10, 8'h38, 32'h0000_0000},
        {1'b1, 4'd9, 8'h34, 32'h0000_000F},
        {1'b0, 4'd9, 8'h34, 32'h0000_0007},
        {1'b1, 4'd9, 8'h34, 32'h0000_0000},
        {1'b1, 4'd2, 8'h2C, 32'h0000_0000}
    };

    function automatic string tag_of(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d, output logic v);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_req = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, output logic acc);
        rx_valid = 1'b1; rx_data = b; acc = rx_ready;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v, acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk("R1", {29'd0, irq, rx_ready, tx_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) bus_write(VEC[i][37:32], VEC[i][31:0]);
            else begin
                bus_read(VEC[i][37:32], d, v);
                chk(tag_of(VEC[i][43:40]), d, VEC[i][31:0]);
            end
        end

        // R2 response valid timing
        bus_read(6'h08, d, v);
        chk("R2", {31'd0, v}, 32'd1);
        @(negedge clk);
        chk("R2", {31'd0, bus_rvalid}, 32'd0);

        // R7 transmit strobe, R10 interrupt output
        bus_write(6'h2C, 32'h2);
        bus_write(6'h1C, 32'hFFFF_FF3C);
        chk("R7", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'h3C});
        chk("R10", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R7", {31'd0, tx_valid}, 32'd0);
        bus_write(6'h30, 32'h3);
        chk("R10", {31'd0, irq}, 32'd0);
        bus_read(6'h34, d, v);
        chk("R8", d, 32'h1);
        bus_write(6'h30, 32'h1);

        // R6 receiver disabled
        chk("R6", {31'd0, rx_ready}, 32'd0);
        rx_send(8'h42, acc);
        bus_read(6'h24, d, v);
        chk("R6", d, 32'h0140_0000);

        // R5 fill the queue
        bus_write(6'h08, 32'h0001_0008);
        for (int i = 0; i < 16; i++) begin
            rx_send(8'h10 + 8'(i), acc);
            chk("R5", {31'd0, acc}, 32'd1);
        end
        chk("R5", {31'd0, rx_ready}, 32'd0);
        rx_send(8'h99, acc);

        // R4 peek twice, R3 layout
        bus_read(6'h24, d, v);
        chk("R3", d, 32'h0141_0010);
        bus_read(6'h24, d, v);
        chk("R4", d, 32'h0141_0010);
        bus_read(6'h34, d, v);
        chk("R9", d, 32'h8);
        bus_write(6'h2C, 32'h8);
        chk("R10", {31'd0, irq}, 32'd1);

        // R5 order, R4 pop
        for (int i = 0; i < 16; i++) begin
            bus_read(6'h20, d, v);
            chk("R5", d, 32'h0141_0010 + 32'(i));
        end
        bus_read(6'h20, d, v);
        chk("R4", d & 32'hFFFF_FF00, 32'h0140_0000);
        // R9 level kept after popping until a write
        bus_read(6'h34, d, v);
        chk("R9", d, 32'h8);
        chk("R9", {31'd0, irq}, 32'd1);
        bus_write(6'h00, 32'h0);
        bus_read(6'h34, d, v);
        chk("R9", d, 32'h0);
        chk("R10", {31'd0, irq}, 32'd0);

        // R4 empty pop did not underflow
        rx_send(8'h77, acc);
        bus_read(6'h24, d, v);
        chk("R4", d, 32'h0141_0077);
        // R8 acknowledging the level bit while data remains
        bus_write(6'h30, 32'h8);
        bus_read(6'h34, d, v);
        chk("R8", d, 32'h8);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule